// File: doc/BRIEF.md
# Per-Block Lock Register Bank

This block holds one lock register for each 64 KB block of a flash array. It decides, in the same cycle as each array access, whether the access may proceed. Each register has three bits: a write lock, a read lock and a sticky lock-down bit. Software reaches the registers through a small register bus. That bus carries a page byte and a 16-bit offset. The register for block n answers at page `BASE_PAGE + n` and offset `REG_OFS`.

On the array side, the block takes a block index, a read strobe, a program/erase strobe and the raw array byte. It returns three things:
- a read-allowed flag;
- a write-allowed flag;
- the gated read byte, which is forced to 00h for a read-locked block.

A program/erase strobe is passed on as `pgm_go` only when writes are allowed.

Two active-low hardware protect pins can also forbid writes. One covers the top boot block and the other covers every other block. Neither pin changes what the registers read back.

Top module: `blk_lock_bank`

## Requirements
- R1: After `rst_n` is released, every lock register reads 01h: write lock set, lock down clear, read lock clear.
- R2: Register layout: bit 0 = write lock, bit 1 = lock down, bit 2 = read lock. Bits 7:3 always read 0, even after a write of ones.
- R3: A register access hits block n only when `reg_page` equals `BASE_PAGE + n` (B8h..BFh by default) and `reg_ofs` equals `REG_OFS` (0002h). A write to any other address changes no register. A read of any other address returns 00h.
- R4: Once set, lock down cannot be cleared by a register write.
- R5: While a block's lock down bit is set, register writes leave that block's write-lock and read-lock bits unchanged.
- R6: A low level of `init_n` at a clock edge returns every register to its reset value 01h. This clears lock down.
- R7: For an access to a read-locked block, `rd_ok` is 0 and `acc_rdata` is 00h. For any other block, `acc_rdata` equals `arr_rdata` and `rd_ok` is 1.
- R8: For an access to a write-locked block, `wr_ok` is 0 and `pgm_go` stays 0 even when `acc_pgm` is 1.
- R9: When `tbl_n` is low, block `NUM_BLK-1` is not writable. When `wp_n` is low, blocks 0 to `NUM_BLK-2` are not writable. Both hold whatever the registers contain.
- R10: Register read data never reflects `tbl_n` or `wp_n`.
- R11: A register write to one block leaves every other block's register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_n | input | 1 | Synchronous initialize, active low; restores defaults |
| reg_page | input | 8 | Register bus page (block-select) byte |
| reg_ofs | input | 16 | Register bus offset within the page |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the addressed page/offset, combinational |
| acc_blk | input | 3 | Array block index of the current access |
| acc_pgm | input | 1 | Program or erase request |
| arr_rdata | input | 8 | Raw byte read from the array |
| acc_rdata | output | 8 | Read byte after read-lock gating |
| rd_ok | output | 1 | Read of `acc_blk` allowed |
| wr_ok | output | 1 | Program/erase of `acc_blk` allowed |
| pgm_go | output | 1 | Program/erase request passed to the array |
| tbl_n | input | 1 | Top boot block protect pin, active low |
| wp_n | input | 1 | Protect pin for all other blocks, active low |

## Verification
The bench builds the block with its defaults: eight blocks, base page B8h and offset 0002h. It uses these values in two ways:
- It probes pages B7h and C0h, which lie just outside the window, and a neighbouring offset, to test the decode edges.
- It tests block 7 as the only block that `tbl_n` covers.

With eight blocks, the bench can lock down one block while it checks that the other seven are unaffected. It can also show that each pin leaves the other's coverage open.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

    localparam int LK_WR_BIT = 0;
    localparam int LK_DN_BIT = 1;
    localparam int LK_RD_BIT = 2;
    localparam int REG_W     = 8;

    typedef struct packed {
        logic rd_lk;
        logic dn_lk;
        logic wr_lk;
    } lock_t;

    localparam lock_t LOCK_RESET = '{rd_lk: 1'b0, dn_lk: 1'b0, wr_lk: 1'b1};

    function automatic logic [REG_W-1:0] lock_to_byte(input lock_t l);
        logic [REG_W-1:0] b;
        b            = '0;
        b[LK_WR_BIT] = l.wr_lk;
        b[LK_DN_BIT] = l.dn_lk;
        b[LK_RD_BIT] = l.rd_lk;
        return b;
    endfunction

endpackage

// File: rtl/blk_lock_dec.sv
module blk_lock_dec #(
    parameter int          NUM_BLK   = 8,
    parameter int          PAGE_W    = 8,
    parameter int          OFS_W     = 16,
    parameter logic [7:0]  BASE_PAGE = 8'hB8,
    parameter logic [15:0] REG_OFS   = 16'h0002,
    localparam int         IDX_W     = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic [PAGE_W-1:0] reg_page,
    input  logic [OFS_W-1:0]  reg_ofs,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    localparam int EXT_W = PAGE_W + 1;

    logic [EXT_W-1:0] page_ext;
    logic [EXT_W-1:0] base_ext;
    logic [EXT_W-1:0] rel;

    always_comb begin
        page_ext = {1'b0, reg_page};
        base_ext = EXT_W'(BASE_PAGE);
        rel      = page_ext - base_ext;
        hit      = (reg_ofs == OFS_W'(REG_OFS)) &&
                   (page_ext >= base_ext) &&
                   (rel < EXT_W'(NUM_BLK));
        idx      = rel[IDX_W-1:0];
    end

endmodule

// File: rtl/blk_lock_cell.sv
module blk_lock_cell
    import blk_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output lock_t            lock_q
);

    typedef struct packed {
        lock_t lk;
    } cell_state_t;

    cell_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!init_n) begin
            state_d.lk = LOCK_RESET;
        end else if (wr_en && !state_q.lk.dn_lk) begin
            state_d.lk.wr_lk = wdata[LK_WR_BIT];
            state_d.lk.rd_lk = wdata[LK_RD_BIT];
            state_d.lk.dn_lk = wdata[LK_DN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.lk <= LOCK_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign lock_q = state_q.lk;

endmodule

// File: rtl/blk_lock_gate.sv
module blk_lock_gate #(
    parameter int  NUM_BLK = 8,
    parameter int  DATA_W  = 8,
    localparam int IDX_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
    localparam int TOP_BLK = NUM_BLK - 1
) (
    input  logic [NUM_BLK-1:0] wr_lk,
    input  logic [NUM_BLK-1:0] rd_lk,
    input  logic [IDX_W-1:0]   acc_blk,
    input  logic               acc_pgm,
    input  logic [DATA_W-1:0]  arr_rdata,
    input  logic               tbl_n,
    input  logic               wp_n,
    output logic [DATA_W-1:0]  acc_rdata,
    output logic               rd_ok,
    output logic               wr_ok,
    output logic               pgm_go
);

    logic [NUM_BLK-1:0] hw_prot;
    logic [NUM_BLK-1:0] wr_allow;

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        if (b == TOP_BLK) begin : g_top
            assign hw_prot[b] = ~tbl_n;
        end else begin : g_main
            assign hw_prot[b] = ~wp_n;
        end
        assign wr_allow[b] = ~wr_lk[b] & ~hw_prot[b];
    end

    always_comb begin
        rd_ok     = ~rd_lk[acc_blk];
        wr_ok     = wr_allow[acc_blk];
        acc_rdata = rd_ok ? arr_rdata : '0;
        pgm_go    = acc_pgm & wr_ok;
    end

endmodule

// File: rtl/blk_lock_bank.sv
module blk_lock_bank
    import blk_lock_pkg::*;
#(
    parameter int          NUM_BLK   = 8,
    parameter logic [7:0]  BASE_PAGE = 8'hB8,
    parameter logic [15:0] REG_OFS   = 16'h0002,
    localparam int         IDX_W     = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_n,
    input  logic [7:0]       reg_page,
    input  logic [15:0]      reg_ofs,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [IDX_W-1:0] acc_blk,
    input  logic             acc_pgm,
    input  logic [7:0]       arr_rdata,
    output logic [7:0]       acc_rdata,
    output logic             rd_ok,
    output logic             wr_ok,
    output logic             pgm_go,
    input  logic             tbl_n,
    input  logic             wp_n
);

    logic               reg_hit;
    logic [IDX_W-1:0]   reg_idx;
    lock_t              lock_q [NUM_BLK];
    logic [NUM_BLK-1:0] wr_lk;
    logic [NUM_BLK-1:0] rd_lk;

    blk_lock_dec #(
        .NUM_BLK  (NUM_BLK),
        .PAGE_W   (8),
        .OFS_W    (16),
        .BASE_PAGE(BASE_PAGE),
        .REG_OFS  (REG_OFS)
    ) i_dec (
        .reg_page(reg_page),
        .reg_ofs (reg_ofs),
        .hit     (reg_hit),
        .idx     (reg_idx)
    );

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_cell
        blk_lock_cell i_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .init_n(init_n),
            .wr_en (reg_we && reg_hit && (reg_idx == IDX_W'(b))),
            .wdata (reg_wdata),
            .lock_q(lock_q[b])
        );
        assign wr_lk[b] = lock_q[b].wr_lk;
        assign rd_lk[b] = lock_q[b].rd_lk;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_hit) begin
            reg_rdata = lock_to_byte(lock_q[reg_idx]);
        end
    end

    blk_lock_gate #(
        .NUM_BLK(NUM_BLK),
        .DATA_W (8)
    ) i_gate (
        .wr_lk    (wr_lk),
        .rd_lk    (rd_lk),
        .acc_blk  (acc_blk),
        .acc_pgm  (acc_pgm),
        .arr_rdata(arr_rdata),
        .tbl_n    (tbl_n),
        .wp_n     (wp_n),
        .acc_rdata(acc_rdata),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok),
        .pgm_go   (pgm_go)
    );

endmodule

// File: rtl/blk_lock_chk.sv
module blk_lock_chk #(
    parameter int          NUM_BLK   = 8,
    parameter logic [7:0]  BASE_PAGE = 8'hB8,
    parameter logic [15:0] REG_OFS   = 16'h0002,
    localparam int         IDX_W     = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_n,
    input logic [7:0]       reg_page,
    input logic [15:0]      reg_ofs,
    input logic             reg_we,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic [IDX_W-1:0] acc_blk,
    input logic             acc_pgm,
    input logic [7:0]       arr_rdata,
    input logic [7:0]       acc_rdata,
    input logic             rd_ok,
    input logic             wr_ok,
    input logic             pgm_go,
    input logic             tbl_n,
    input logic             wp_n
);

    localparam int unsigned TOP_PAGE = int'(BASE_PAGE) + NUM_BLK - 1;

    logic addr_in_map;
    assign addr_in_map = (reg_ofs == REG_OFS) &&
                         (int'(reg_page) >= int'(BASE_PAGE)) &&
                         (int'(reg_page) <= int'(TOP_PAGE));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:3] == 5'b0);

    a_r3_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_in_map |-> reg_rdata == 8'h00);

    a_r4_r5_frozen_when_down: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1] && init_n) |=>
            ((reg_page != $past(reg_page)) || (reg_ofs != $past(reg_ofs)) ||
             (reg_rdata == $past(reg_rdata))));

    a_r7_read_lock_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |-> acc_rdata == 8'h00);

    a_r8_no_go_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |-> !pgm_go);

    a_r9_top_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (!tbl_n && (int'(acc_blk) == NUM_BLK - 1)) |-> !wr_ok);

    a_r9_main_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && (int'(acc_blk) != NUM_BLK - 1)) |-> !wr_ok);

    a_r6_init_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_n && addr_in_map) |=>
            ((reg_page != $past(reg_page)) || (reg_ofs != $past(reg_ofs)) ||
             (reg_rdata == 8'h01) || !init_n));

endmodule

bind blk_lock_bank blk_lock_chk #(
    .NUM_BLK  (NUM_BLK),
    .BASE_PAGE(BASE_PAGE),
    .REG_OFS  (REG_OFS)
) i_blk_lock_chk (.*);

// File: tb/test_blk_lock_bank.sv
module test_blk_lock_bank;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_n = 1'b1;
    logic [7:0] reg_page = 8'h00;
    logic [15:0] reg_ofs = 16'h0000;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [2:0] acc_blk = 3'd0;
    logic       acc_pgm = 1'b0;
    logic [7:0] arr_rdata = 8'h00;
    logic [7:0] acc_rdata;
    logic       rd_ok, wr_ok, pgm_go;
    logic       tbl_n = 1'b1;
    logic       wp_n = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_lock_bank i_blk_lock_bank (
        .clk(clk), .rst_n(rst_n), .init_n(init_n),
        .reg_page(reg_page), .reg_ofs(reg_ofs), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_blk(acc_blk), .acc_pgm(acc_pgm), .arr_rdata(arr_rdata),
        .acc_rdata(acc_rdata), .rd_ok(rd_ok), .wr_ok(wr_ok), .pgm_go(pgm_go),
        .tbl_n(tbl_n), .wp_n(wp_n)
    );

    // op: 0 = register write, 1 = register read, 2 = array read (wd = array byte), 3 = program request
    typedef struct packed {
        logic [1:0] op;
        logic [2:0] blk;
        logic [7:0] wd;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{op: 2'd1, blk: 3'd0, wd: 8'h00, exp: 8'h01}, // R1
        '{op: 2'd3, blk: 3'd0, wd: 8'h00, exp: 8'h00}, // R8
        '{op: 2'd0, blk: 3'd0, wd: 8'h00, exp: 8'h00},
        '{op: 2'd1, blk: 3'd0, wd: 8'h00, exp: 8'h00}, // R2
        '{op: 2'd3, blk: 3'd0, wd: 8'h00, exp: 8'h01}, // R8
        '{op: 2'd0, blk: 3'd3, wd: 8'hFC, exp: 8'h00},
        '{op: 2'd1, blk: 3'd3, wd: 8'h00, exp: 8'h04}, // R2
        '{op: 2'd2, blk: 3'd3, wd: 8'hA5, exp: 8'h00}, // R7
        '{op: 2'd2, blk: 3'd0, wd: 8'hA5, exp: 8'hA5}, // R7
        '{op: 2'd0, blk: 3'd5, wd: 8'h02, exp: 8'h00},
        '{op: 2'd1, blk: 3'd5, wd: 8'h00, exp: 8'h02}, // R4
        '{op: 2'd0, blk: 3'd5, wd: 8'h05, exp: 8'h00},
        '{op: 2'd1, blk: 3'd5, wd: 8'h00, exp: 8'h02}, // R5
        '{op: 2'd0, blk: 3'd5, wd: 8'h00, exp: 8'h00},
        '{op: 2'd1, blk: 3'd5, wd: 8'h00, exp: 8'h02}, // R4
        '{op: 2'd3, blk: 3'd5, wd: 8'h00, exp: 8'h01}, // R5
        '{op: 2'd1, blk: 3'd1, wd: 8'h00, exp: 8'h01}  // R11
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic set_addr(input logic [7:0] page, input logic [15:0] ofs);
        @(negedge clk);
        reg_page = page;
        reg_ofs  = ofs;
        reg_we   = 1'b0;
        #1;
    endtask

    task automatic reg_write(input logic [7:0] page, input logic [15:0] ofs, input logic [7:0] d);
        @(negedge clk);
        reg_page  = page;
        reg_ofs   = ofs;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic reg_read(input string req, input logic [7:0] page,
                            input logic [15:0] ofs, input logic [7:0] exp);
        set_addr(page, ofs);
        check(req, reg_rdata, exp);
    endtask

    task automatic pgm_check(input string req, input logic [2:0] blk, input logic exp);
        @(negedge clk);
        acc_blk = blk;
        acc_pgm = 1'b1;
        #1;
        check(req, {7'b0, pgm_go}, {7'b0, exp});
        check(req, {7'b0, wr_ok}, {7'b0, exp});
        acc_pgm = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            case (v.op)
                2'd0: reg_write(8'hB8 + 8'(v.blk), 16'h0002, v.wd);
                2'd1: reg_read("R1/R2/R4/R5/R11 vector", 8'hB8 + 8'(v.blk), 16'h0002, v.exp);
                2'd2: begin
                    @(negedge clk);
                    acc_blk   = v.blk;
                    arr_rdata = v.wd;
                    #1;
                    check("R7 vector", acc_rdata, v.exp);
                    check("R7 rd_ok", {7'b0, rd_ok}, {7'b0, (v.exp == v.wd)});
                end
                default: pgm_check("R8 vector", v.blk, v.exp[0]);
            endcase
        end

        // R6: init clears lock down
        @(negedge clk);
        init_n = 1'b0;
        @(negedge clk);
        init_n = 1'b1;
        reg_read("R6 locked-down block restored", 8'hBD, 16'h0002, 8'h01);
        reg_read("R6 read lock cleared", 8'hBB, 16'h0002, 8'h01);

        // R1: reset of all registers
        reg_write(8'hB9, 16'h0002, 8'h06);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < 8; b++) begin
            reg_read("R1 reset default", 8'hB8 + 8'(b), 16'h0002, 8'h01);
        end

        // R3: decode edges
        reg_write(8'hB8, 16'h0003, 8'h00);
        reg_read("R3 wrong offset no write", 8'hB8, 16'h0002, 8'h01);
        reg_read("R3 wrong offset reads zero", 8'hB8, 16'h0003, 8'h00);
        reg_write(8'hB7, 16'h0002, 8'h00);
        reg_write(8'hC0, 16'h0002, 8'h00);
        reg_read("R3 page below", 8'hB7, 16'h0002, 8'h00);
        reg_read("R3 page above", 8'hC0, 16'h0002, 8'h00);
        reg_read("R3 block0 unaffected", 8'hB8, 16'h0002, 8'h01);
        reg_read("R3 block7 unaffected", 8'hBF, 16'h0002, 8'h01);

        // R9 / R10: hardware pins
        reg_write(8'hBA, 16'h0002, 8'h00);
        reg_write(8'hBF, 16'h0002, 8'h00);
        pgm_check("R9 block7 open", 3'd7, 1'b1);
        @(negedge clk);
        tbl_n = 1'b0;
        pgm_check("R9 tbl protects block7", 3'd7, 1'b0);
        pgm_check("R9 tbl leaves block2", 3'd2, 1'b1);
        reg_read("R10 tbl not visible", 8'hBF, 16'h0002, 8'h00);
        @(negedge clk);
        tbl_n = 1'b1;
        wp_n  = 1'b0;
        pgm_check("R9 wp protects block2", 3'd2, 1'b0);
        pgm_check("R9 wp leaves block7", 3'd7, 1'b1);
        reg_read("R10 wp not visible", 8'hBA, 16'h0002, 8'h00);
        @(negedge clk);
        wp_n = 1'b1;
        pgm_check("R9 pins released", 3'd2, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule